// File: doc/BRIEF.md
# Reset-Configured Quad/Dual FIFO Bank

This block is a bank of clock-domain-crossing FIFOs whose organisation is fixed at master reset. While `mrst_n` is held low, four configuration pins are sampled on `wr_clk[0]`. That clock must toggle during reset. The pins choose three things:

- **Partitioning.** Quad mode gives four independent 10-bit FIFOs, one per lane. Dual mode gives two FIFOs.
- **Output timing.** Standard, or first-word-fall-through (FWFT).
- **Port widths.** The write width and the read width are chosen separately, 10 or 20 bits, and apply in dual mode only.

Once reset is released the pins are ignored.

Each lane has its own write clock and read clock. Writes use a valid/ready handshake: a beat moves on a rising write-clock edge when `wr_valid` and `wr_ready` are both high. `wr_ready` falls when the next beat would not fit.

On the read side, `rd_ready` is the consumer's request. Its meaning depends on the timing mode:

- **FWFT.** `rd_valid` means `rd_data` already holds the head word. That word stays stable until `rd_ready` is seen high at a read-clock edge.
- **Standard.** `rd_valid` means "not empty". A read (`rd_valid` and `rd_ready` at an edge) puts the next word on `rd_data` after that edge.

In dual mode, FIFO k is controlled through lane 2k. Its 20-bit data is lane 2k's data (low half) joined with lane 2k+1's data (high half). Lane data occupies bits [10l+9:10l] of the data buses. Storage is counted in 10-bit units. Each lane contributes DEPTH units, and gray-coded pointers cross between clock domains through two-flop synchronisers.

Top module: `fifo_bank_cfg`

## Requirements
- R1: Configuration is taken from `cfg_quad`, `cfg_fwft`, `cfg_wr_wide` and `cfg_rd_wide` while `mrst_n` is low. Changing these pins after release has no effect on behaviour.
- R2: With `cfg_quad`=1, each of the four lanes is an independent 10-bit FIFO of DEPTH words. Words leave in write order.
- R3: With `cfg_quad`=0, lanes 0 and 2 each control a FIFO holding 2*DEPTH 10-bit units, which is DEPTH words at 20-bit write width. On lanes 1 and 3, `wr_ready` and `rd_valid` stay 0.
- R4: In quad mode the width pins are overridden and every port is 10 bits wide.
- R5: Dual mode with 20-bit write and 10-bit read returns each written word as two reads, low half first. The high lane's `rd_data` reads 0.
- R6: Dual mode with 10-bit write and 20-bit read pairs two written words. The first becomes the low half. No read word is offered until both words are stored.
- R7: A write while `wr_ready` is 0 is dropped and does not disturb the stored contents.
- R8: A read request while `rd_valid` is 0 is ignored. `rd_data` holds, and the read pointer does not move.
- R9: In FWFT mode the head word appears with `rd_valid`=1 without any request. It is held while `rd_ready`=0, and `rd_valid` falls once the last word is consumed.
- R10: In standard mode `rd_data` changes only on a read.
- R11: Master reset empties every FIFO. After reset, `rd_valid`=0 and `rd_data`=0 on all lanes, and `wr_ready`=1 on all active lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mrst_n | input | 1 | Active-low master reset; configuration sampled while low |
| cfg_quad | input | 1 | 1 = four 10-bit FIFOs, 0 = two FIFOs |
| cfg_fwft | input | 1 | 1 = first-word-fall-through, 0 = standard timing |
| cfg_wr_wide | input | 1 | 1 = 20-bit write ports (dual only) |
| cfg_rd_wide | input | 1 | 1 = 20-bit read ports (dual only) |
| wr_clk | input | 4 | Per-lane write clocks |
| wr_valid | input | 4 | Per-lane write request |
| wr_ready | output | 4 | Per-lane room for one more beat |
| wr_data | input | 40 | Lane l data at [10l+9:10l] |
| rd_clk | input | 4 | Per-lane read clocks |
| rd_ready | input | 4 | Per-lane read request / consume |
| rd_valid | output | 4 | FWFT: data valid; standard: not empty |
| rd_data | output | 40 | Lane l read data at [10l+9:10l] |

## Verification
Quad mode is run with both width pins high, so that a design which fails to force 10-bit ports corrupts lane data. Independent lanes are written with distinct values to show that they do not share pointers. A fill to DEPTH followed by an extra beat shows whether capacity is right and whether overflow is dropped. An empty-lane read followed by a fresh word shows whether an underflow moved the pointer.

Each width pairing (20-bit write with 10-bit read, and 10-bit write with 20-bit read) uses asymmetric half-words, which exposes half-order swaps. A single lone 10-bit write tells a correct pairing apart from one that offers half a word. The standard and FWFT runs distinguish head-word presentation from read-triggered update.

// File: rtl/fifo_bank_pkg.sv
`timescale 1ns/1ps
package fifo_bank_pkg;
  typedef struct packed {
    logic quad;
    logic fwft;
    logic wr_wide;
    logic rd_wide;
  } bank_cfg_t;
endpackage

// File: rtl/bank_cfg_capture.sv
`timescale 1ns/1ps
module bank_cfg_capture
  import fifo_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_quad,
  input  logic      pin_fwft,
  input  logic      pin_wr_wide,
  input  logic      pin_rd_wide,
  output bank_cfg_t cfg
);
  // Loaded on every edge while reset is held; frozen afterwards.
  // Quad mode forces both widths narrow.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.quad    <= pin_quad;
      cfg.fwft    <= pin_fwft;
      cfg.wr_wide <= pin_wr_wide & ~pin_quad;
      cfg.rd_wide <= pin_rd_wide & ~pin_quad;
    end
  end

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg));
  // R4
  quad_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.quad |-> !(cfg.wr_wide || cfg.rd_wide));
endmodule

// File: rtl/ptr_sync.sv
`timescale 1ns/1ps
module ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_engine.sv
`timescale 1ns/1ps
module fifo_engine #(
  parameter int DAW = 3,
  parameter int DW  = 20
) (
  input  logic           wclk,
  input  logic           rclk,
  input  logic           rst_n,
  input  logic           wide_store,
  input  logic           wstep2,
  input  logic           rstep2,
  input  logic           fwft,
  input  logic           wr_valid,
  output logic           wr_ready,
  output logic           push,
  output logic [DAW-1:0] wrow,
  output logic           wbank,
  input  logic           rd_ready,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic [DAW-1:0] rrow,
  output logic           rbank,
  input  logic [DW-1:0]  head
);
  localparam int PW    = DAW + 2;
  localparam int DEPTH = 1 << DAW;

  // Coarse pointers (always even) are crossed as gray(ptr/2) so one bit flips per step.
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b, input logic coarse);
    logic [PW-1:0] s;
    s = coarse ? (b >> 1) : b;
    return s ^ (s >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g, input logic coarse);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return coarse ? (b << 1) : b;
  endfunction

  logic [PW:0]   cap;
  logic [PW-1:0] wstep, rstep;
  assign cap   = wide_store ? (PW+1)'(2 * DEPTH) : (PW+1)'(DEPTH);
  assign wstep = wstep2 ? PW'(2) : PW'(1);
  assign rstep = rstep2 ? PW'(2) : PW'(1);

  // write domain
  logic [PW-1:0] wbin, wgray, rgray_w, rbin_w, used_w, wnext;
  ptr_sync #(.W(PW)) u_rsync (.clk(wclk), .rst_n(rst_n), .d(rgray_r_q), .q(rgray_w));
  assign rbin_w   = from_gray(rgray_w, rstep2);
  assign used_w   = wbin - rbin_w;
  assign wr_ready = ({1'b0, used_w} + {1'b0, wstep}) <= cap;
  assign push     = wr_valid & wr_ready;
  assign wnext    = wbin + wstep;
  assign wrow     = wide_store ? wbin[DAW:1] : wbin[DAW-1:0];
  assign wbank    = wide_store & wbin[0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wnext;
      wgray <= to_gray(wnext, wstep2);
    end
  end

  // read domain
  logic [PW-1:0] rbin, rgray_r_q, wgray_r, wbin_r, avail, rnext;
  logic          can_pop, pop, oval;
  ptr_sync #(.W(PW)) u_wsync (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));
  assign wbin_r  = from_gray(wgray_r, wstep2);
  assign avail   = wbin_r - rbin;
  assign can_pop = avail >= rstep;
  assign pop     = fwft ? (can_pop & (~oval | rd_ready)) : (can_pop & rd_ready);
  assign rnext   = rbin + rstep;
  assign rrow    = wide_store ? rbin[DAW:1] : rbin[DAW-1:0];
  assign rbank   = wide_store & rbin[0];
  assign rd_valid = fwft ? oval : can_pop;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray_r_q <= '0;
      rd_data   <= '0;
      oval      <= 1'b0;
    end else begin
      if (pop) begin
        rbin      <= rnext;
        rgray_r_q <= to_gray(rnext, rstep2);
        rd_data   <= head;
      end
      if (fwft) begin
        if (pop)           oval <= 1'b1;
        else if (rd_ready) oval <= 1'b0;
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    {1'b0, used_w} <= cap);
  // R8
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    {1'b0, avail} <= cap);
  // R9
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && oval && !rd_ready) |=> (oval && $stable(rd_data)));
  // R10
  std_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && !(rd_ready && can_pop)) |=> $stable(rd_data));
  // R2
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_lane_pair.sv
`timescale 1ns/1ps
module fifo_lane_pair
  import fifo_bank_pkg::*;
#(
  parameter int W   = 10,
  parameter int DAW = 3
) (
  input  logic         rst_n,
  input  bank_cfg_t    cfg,
  input  logic         wr_clk_lo,
  input  logic         wr_clk_hi,
  input  logic         rd_clk_lo,
  input  logic         rd_clk_hi,
  input  logic         wr_valid_lo,
  input  logic         wr_valid_hi,
  output logic         wr_ready_lo,
  output logic         wr_ready_hi,
  input  logic [W-1:0] wr_data_lo,
  input  logic [W-1:0] wr_data_hi,
  input  logic         rd_ready_lo,
  input  logic         rd_ready_hi,
  output logic         rd_valid_lo,
  output logic         rd_valid_hi,
  output logic [W-1:0] rd_data_lo,
  output logic [W-1:0] rd_data_hi
);
  localparam int DEPTH = 1 << DAW;

  logic [W-1:0]   mem_lo [DEPTH];
  logic [W-1:0]   mem_hi [DEPTH];
  logic           push0, push1, wbank0, wbank1, rbank0, rbank1;
  logic           rv0, rv1, wrdy0, wrdy1;
  logic [DAW-1:0] wrow0, wrow1, rrow0, rrow1;
  logic [2*W-1:0] head0, data0;
  logic [W-1:0]   head1, data1;

  fifo_engine #(.DAW(DAW), .DW(2*W)) u_eng0 (
    .wclk(wr_clk_lo), .rclk(rd_clk_lo), .rst_n(rst_n),
    .wide_store(~cfg.quad), .wstep2(cfg.wr_wide), .rstep2(cfg.rd_wide), .fwft(cfg.fwft),
    .wr_valid(wr_valid_lo), .wr_ready(wrdy0), .push(push0), .wrow(wrow0), .wbank(wbank0),
    .rd_ready(rd_ready_lo), .rd_valid(rv0), .rd_data(data0), .rrow(rrow0), .rbank(rbank0),
    .head(head0));

  fifo_engine #(.DAW(DAW), .DW(W)) u_eng1 (
    .wclk(wr_clk_hi), .rclk(rd_clk_hi), .rst_n(rst_n),
    .wide_store(1'b0), .wstep2(1'b0), .rstep2(1'b0), .fwft(cfg.fwft),
    .wr_valid(wr_valid_hi & cfg.quad), .wr_ready(wrdy1), .push(push1), .wrow(wrow1),
    .wbank(wbank1), .rd_ready(rd_ready_hi & cfg.quad), .rd_valid(rv1), .rd_data(data1),
    .rrow(rrow1), .rbank(rbank1), .head(head1));

  // Bank write ports; the high bank follows the low lane's clock in dual mode.
  logic           lo_we, hi_we, hi_clk;
  logic [DAW-1:0] hi_row;
  logic [W-1:0]   hi_d;
  assign hi_clk = cfg.quad ? wr_clk_hi : wr_clk_lo;
  assign lo_we  = push0 & (cfg.wr_wide | ~wbank0);
  assign hi_we  = cfg.quad ? (push1 & ~wbank1) : (push0 & (cfg.wr_wide | wbank0));
  assign hi_row = cfg.quad ? wrow1 : wrow0;
  assign hi_d   = (cfg.quad || cfg.wr_wide) ? wr_data_hi : wr_data_lo;

  always_ff @(posedge wr_clk_lo) begin
    if (lo_we) mem_lo[wrow0] <= wr_data_lo;
  end
  always_ff @(posedge hi_clk) begin
    if (hi_we) mem_hi[hi_row] <= hi_d;
  end

  // Head words seen by each read engine.
  always_comb begin
    if (cfg.rd_wide)  head0 = {mem_hi[rrow0], mem_lo[rrow0]};
    else if (rbank0)  head0 = {{W{1'b0}}, mem_hi[rrow0]};
    else              head0 = {{W{1'b0}}, mem_lo[rrow0]};
  end
  assign head1 = rbank1 ? '0 : mem_hi[rrow1];

  assign wr_ready_lo = wrdy0;
  assign rd_valid_lo = rv0;
  assign rd_data_lo  = data0[W-1:0];
  assign wr_ready_hi = cfg.quad & wrdy1;
  assign rd_valid_hi = cfg.quad & rv1;
  assign rd_data_hi  = cfg.quad ? data1 : data0[2*W-1:W];

  // R3
  idle_hi_chk: assert property (@(posedge wr_clk_lo) disable iff (!rst_n)
    !cfg.quad |-> !(wr_ready_hi || rd_valid_hi));
endmodule

// File: rtl/fifo_bank_cfg.sv
`timescale 1ns/1ps
module fifo_bank_cfg
  import fifo_bank_pkg::*;
#(
  parameter int LANE_W = 10,
  parameter int DEPTH  = 8
) (
  input  logic                mrst_n,
  input  logic                cfg_quad,
  input  logic                cfg_fwft,
  input  logic                cfg_wr_wide,
  input  logic                cfg_rd_wide,
  input  logic [3:0]          wr_clk,
  input  logic [3:0]          wr_valid,
  output logic [3:0]          wr_ready,
  input  logic [4*LANE_W-1:0] wr_data,
  input  logic [3:0]          rd_clk,
  input  logic [3:0]          rd_ready,
  output logic [3:0]          rd_valid,
  output logic [4*LANE_W-1:0] rd_data
);
  localparam int DAW   = $clog2(DEPTH);
  localparam int PAIRS = 2;

  bank_cfg_t cfg;

  bank_cfg_capture u_cfg (
    .clk(wr_clk[0]), .rst_n(mrst_n),
    .pin_quad(cfg_quad), .pin_fwft(cfg_fwft),
    .pin_wr_wide(cfg_wr_wide), .pin_rd_wide(cfg_rd_wide), .cfg(cfg));

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int L = 2 * p;
    localparam int H = 2 * p + 1;
    fifo_lane_pair #(.W(LANE_W), .DAW(DAW)) u_pair (
      .rst_n(mrst_n), .cfg(cfg),
      .wr_clk_lo(wr_clk[L]), .wr_clk_hi(wr_clk[H]),
      .rd_clk_lo(rd_clk[L]), .rd_clk_hi(rd_clk[H]),
      .wr_valid_lo(wr_valid[L]), .wr_valid_hi(wr_valid[H]),
      .wr_ready_lo(wr_ready[L]), .wr_ready_hi(wr_ready[H]),
      .wr_data_lo(wr_data[L*LANE_W +: LANE_W]), .wr_data_hi(wr_data[H*LANE_W +: LANE_W]),
      .rd_ready_lo(rd_ready[L]), .rd_ready_hi(rd_ready[H]),
      .rd_valid_lo(rd_valid[L]), .rd_valid_hi(rd_valid[H]),
      .rd_data_lo(rd_data[L*LANE_W +: LANE_W]), .rd_data_hi(rd_data[H*LANE_W +: LANE_W]));
  end
endmodule

// File: tb/fifo_bank_cfg_test.sv
`timescale 1ns/1ps
module fifo_bank_cfg_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        p_quad = 1'b1, p_fwft = 1'b0, p_ww = 1'b0, p_rw = 1'b0;
  logic [3:0]  wr_valid = '0, rd_ready = '0, wr_ready, rd_valid;
  logic [39:0] wr_data = '0, rd_data;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  fifo_bank_cfg #(.LANE_W(10), .DEPTH(DEPTH)) uut (
    .mrst_n(mrst_n), .cfg_quad(p_quad), .cfg_fwft(p_fwft),
    .cfg_wr_wide(p_ww), .cfg_rd_wide(p_rw),
    .wr_clk({4{clk}}), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_clk({4{clk}}), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic q, input logic f, input logic ww, input logic rw);
    @(negedge clk);
    mrst_n = 1'b0; wr_valid = '0; rd_ready = '0;
    p_quad = q; p_fwft = f; p_ww = ww; p_rw = rw;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
    // R1: pins move after release and must be ignored
    p_quad = ~q; p_fwft = ~f; p_ww = ~ww; p_rw = ~rw;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input int lane, input logic [9:0] lo, input logic [9:0] hi);
    @(negedge clk);
    wr_valid[lane] = 1'b1;
    wr_data[lane*10 +: 10] = lo;
    if (lane < 3) wr_data[(lane+1)*10 +: 10] = hi;
    @(negedge clk);
    wr_valid[lane] = 1'b0;
  endtask

  task automatic pop(input int lane);
    @(negedge clk);
    rd_ready[lane] = 1'b1;
    @(negedge clk);
    rd_ready[lane] = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset(1, 0, 0, 0);
    chk("R11 wr_ready", {36'd0, wr_ready}, 40'hF);
    chk("R11 rd_valid", {36'd0, rd_valid}, 40'h0);
    chk("R11 rd_data", rd_data, 40'h0);
  endtask

  task automatic t_quad_lanes();
    do_reset(1, 0, 1, 1);  // R4: width pins high but quad forces 10 bits
    for (int l = 0; l < 4; l++) push(l, 10'h300 + 10'(l*17), 10'h3FF);
    settle();
    chk("R2 all lanes hold data", {36'd0, rd_valid}, 40'hF);
    for (int l = 0; l < 4; l++) begin
      pop(l);
      chk("R4 lane word 10-bit", {30'd0, rd_data[l*10 +: 10]}, {30'd0, 10'h300 + 10'(l*17)});
    end
    chk("R2 lanes drained", {36'd0, rd_valid}, 40'h0);
    repeat (3) @(negedge clk);
    chk("R10 data held without read", {30'd0, rd_data[30 +: 10]}, {30'd0, 10'h300 + 10'd51});
  endtask

  task automatic t_quad_full_empty();
    do_reset(1, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) push(0, 10'(i + 5), 10'h0);
    chk("R7 full drops ready", {39'd0, wr_ready[0]}, 40'h0);
    chk("R2 other lane free", {39'd0, wr_ready[1]}, 40'h1);
    push(0, 10'h3FF, 10'h0);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      pop(0);
      chk("R2 order", {30'd0, rd_data[9:0]}, {30'd0, 10'(i + 5)});
    end
    chk("R7 overflow beat not stored", {39'd0, rd_valid[0]}, 40'h0);
    pop(0);
    chk("R8 empty read holds data", {30'd0, rd_data[9:0]}, {30'd0, 10'(DEPTH + 4)});
    push(0, 10'h055, 10'h0);
    settle();
    pop(0);
    chk("R8 pointer unmoved", {30'd0, rd_data[9:0]}, 40'h055);
  endtask

  task automatic t_fwft();
    do_reset(1, 1, 0, 0);
    push(2, 10'h1A1, 10'h0);
    push(2, 10'h2B2, 10'h0);
    settle();
    chk("R9 head valid", {39'd0, rd_valid[2]}, 40'h1);
    chk("R9 head shown", {30'd0, rd_data[20 +: 10]}, 40'h1A1);
    repeat (3) @(negedge clk);
    chk("R9 head held", {30'd0, rd_data[20 +: 10]}, 40'h1A1);
    pop(2);
    chk("R9 next word", {30'd0, rd_data[20 +: 10]}, 40'h2B2);
    pop(2);
    chk("R9 valid falls", {39'd0, rd_valid[2]}, 40'h0);
  endtask

  task automatic t_dual_wide_in();
    do_reset(0, 0, 1, 0);
    chk("R1 dual kept after pin change", {36'd0, wr_ready}, 40'h5);
    push(0, 10'h0AA, 10'h155);
    push(0, 10'h00F, 10'h0F0);
    settle();
    pop(0); chk("R5 low half first", {30'd0, rd_data[9:0]}, 40'h0AA);
    chk("R5 high lane zero", {30'd0, rd_data[19:10]}, 40'h0);
    pop(0); chk("R5 high half second", {30'd0, rd_data[9:0]}, 40'h155);
    pop(0); chk("R5 word2 low", {30'd0, rd_data[9:0]}, 40'h00F);
    pop(0); chk("R5 word2 high", {30'd0, rd_data[9:0]}, 40'h0F0);
    for (int i = 0; i < DEPTH; i++) push(2, 10'(i), 10'(i + 100));
    chk("R3 dual holds DEPTH wide words", {36'd0, wr_ready}, 40'h1);
    settle();
    chk("R3 lanes 1 and 3 idle", {36'd0, rd_valid}, 40'h4);
  endtask

  task automatic t_dual_wide_out();
    do_reset(0, 1, 0, 1);
    push(0, 10'h123, 10'h3FF);
    settle();
    chk("R6 half word not offered", {39'd0, rd_valid[0]}, 40'h0);
    push(0, 10'h2BC, 10'h3FF);
    settle();
    chk("R6 pair offered", {39'd0, rd_valid[0]}, 40'h1);
    chk("R6 first is low half", {20'd0, rd_data[19:0]}, {20'd0, 10'h2BC, 10'h123});
  endtask

  initial begin
    t_reset_state();
    t_quad_lanes();
    t_quad_full_empty();
    t_fwft();
    t_dual_wide_in();
    t_dual_wide_out();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule